// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler Unit

This block holds an 8-bit counting timer, a watchdog counter and one 8-bit divider that the two share. An owner-select input gives the divider to exactly one of them. When the timer owns it, the divider sits between the timer's count source and the timer register. When the watchdog owns it, the divider sits after the watchdog counter's overflow. The unit that does not own the divider runs undivided.

The timer counts either the instruction-cycle enable or edges of an external pin. The pin goes through a two-stage synchronizer that is clocked by the cycle enable, and an edge-select input chooses which edge counts. A 3-bit ratio field picks one tap of the divider.

The divider cannot be read or written. It is cleared by a timer write while the timer owns it, and by the watchdog clear strobe while the watchdog owns it. The watchdog counter is advanced by an externally supplied tick. Its output is a one-cycle timeout pulse, and that pulse occurs only while the watchdog is enabled. No pin carries a data stream, so every pin is plain control or status with no back-pressure.

Top module: `shpre_top`

## Requirements
- R1: After reset, `tmr_value` is 0, `wdt_timeout` is 0 and the divider holds all zeros.
- R2: With `wdt_owns` = 0 (timer owns the divider), the timer advances once every 2^(k+1) source ticks counted from the last divider clear, where k is the value of `ratio` (000 gives 1:2, 111 gives 1:256).
- R3: With `wdt_owns` = 1, the timer advances once per source tick and wraps from 0xFF to 0x00.
- R4: `src_pin` = 0 selects `cyc_en` as the source tick. `src_pin` = 1 selects edges of `ext_pin`, and then cycles of `cyc_en` alone do not count. With `cyc_en` held high, a pin change driven before edge n shows up as an increment after edge n+2: two synchronizer stages plus the edge detector.
- R5: `pin_fall` = 0 counts rising edges of `ext_pin` and `pin_fall` = 1 counts falling edges. The other edge is ignored.
- R6: A pulse on `tmr_wr` loads `tmr_wdata` into `tmr_value` at the next edge and takes priority over an increment. While `wdt_owns` = 0, it also clears the divider.
- R7: The watchdog counter is WDT_W bits wide and advances on each `wdt_tick` while `wdt_en` = 1. With `wdt_owns` = 0, every 2^WDT_W-th tick produces `wdt_timeout` high for exactly the one cycle after that tick's edge.
- R8: With `wdt_owns` = 1, a timeout occurs on every 2^k-th watchdog overflow (000 gives 1:1, 111 gives 1:128).
- R9: `wdt_clr` clears the watchdog counter. It clears the divider only while `wdt_owns` = 1. A timer write does not clear the divider while `wdt_owns` = 1.
- R10: While `wdt_en` = 0, `wdt_timeout` stays 0 and ticks do not advance the watchdog counter.
- R11: Without `cyc_en` and without a write, `tmr_value` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable, one clock wide |
| ext_pin | input | 1 | External count pin (asynchronous) |
| pin_fall | input | 1 | Edge select: 0 rising, 1 falling |
| src_pin | input | 1 | Timer source: 0 cycle enable, 1 pin |
| ratio | input | 3 | Divider tap select |
| wdt_owns | input | 1 | Divider owner: 0 timer, 1 watchdog |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tick | input | 1 | Watchdog base tick, one clock wide |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_value | output | 8 | Current timer value |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The timer is driven with bursts of cycle enables of lengths chosen just below and at a divide boundary, at ratios 1:2, 1:8 and 1:256. This tells a correct tap from a neighbouring one. A partial count followed by a write, or by a watchdog clear, shows whether the divider was cleared by the right owner.

Single pin transitions are sampled edge by edge to pin down the synchronizer latency, and both edge polarities are exercised. Watchdog ticks are issued one at a time and the timeout is read after each one, so a pulse that comes one overflow early or late, or lasts two cycles, is caught.

// File: rtl/shpre_pkg.sv
package shpre_pkg;
  typedef enum logic {
    OWNER_TMR = 1'b0,
    OWNER_WDT = 1'b1
  } owner_e;
endpackage

// File: rtl/shpre_pin_sync.sv
module shpre_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_tick
);
  logic              pin_pol;
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  // polarity folded in front so only a rising edge is detected
  assign pin_pol = pin ^ fall_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else if (cyc_en) begin
      shreg  <= {shreg[STAGES-2:0], pin_pol};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign edge_tick = cyc_en & shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/shpre_divider.sv
module shpre_divider
  import shpre_pkg::*;
#(
  parameter int W = 8,
  localparam int SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  owner_e           owner,
  input  logic             tick_in,
  input  logic             clear,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             div_tick,
  output logic [W-1:0]     cnt
);
  logic [W-1:0]     carry;
  logic [SEL_W-1:0] wdt_idx;
  logic             tap_hit;

  assign carry[0] = cnt[0];
  for (genvar g = 1; g < W; g++) begin : g_carry
    assign carry[g] = carry[g-1] & cnt[g];
  end

  assign wdt_idx = tap_sel - SEL_W'(1);

  always_comb begin
    if (owner == OWNER_WDT) begin
      tap_hit = (tap_sel == '0) ? 1'b1 : carry[wdt_idx];
    end else begin
      tap_hit = carry[tap_sel];
    end
  end

  assign div_tick = tick_in & tap_hit & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/shpre_wdt_core.sv
module shpre_wdt_core #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          clr,
  output logic          ovf,
  output logic [CW-1:0] cnt
);
  logic advance;

  assign advance = en & tick & ~clr;
  assign ovf     = advance & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/shpre_timer_reg.sv
module shpre_timer_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr) begin
      value <= wdata;
    end else if (inc) begin
      value <= value + W'(1);
    end
  end
endmodule

// File: rtl/shpre_top.sv
module shpre_top
  import shpre_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int TMR_W  = 8,
  parameter int WDT_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_en,
  input  logic                     ext_pin,
  input  logic                     pin_fall,
  input  logic                     src_pin,
  input  logic [$clog2(PRE_W)-1:0] ratio,
  input  logic                     wdt_owns,
  input  logic                     wdt_en,
  input  logic                     wdt_tick,
  input  logic                     tmr_wr,
  input  logic [TMR_W-1:0]         tmr_wdata,
  input  logic                     wdt_clr,
  output logic [TMR_W-1:0]         tmr_value,
  output logic                     wdt_timeout
);
  owner_e             owner;
  logic               pin_tick;
  logic               src_tick;
  logic               wdt_ovf;
  logic [WDT_W-1:0]   wdt_cnt;
  logic               pre_in;
  logic               pre_clr;
  logic               pre_out;
  logic [PRE_W-1:0]   pre_cnt;
  logic               tmr_inc;
  logic               timeout_q;

  assign owner = owner_e'(wdt_owns);

  shpre_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .pin      (ext_pin),
    .fall_sel (pin_fall),
    .edge_tick(pin_tick)
  );

  assign src_tick = src_pin ? pin_tick : cyc_en;

  shpre_wdt_core #(.CW(WDT_W)) u_wdt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (wdt_en),
    .tick (wdt_tick),
    .clr  (wdt_clr),
    .ovf  (wdt_ovf),
    .cnt  (wdt_cnt)
  );

  // divider routing: input and clear source follow the owner
  always_comb begin
    if (owner == OWNER_WDT) begin
      pre_in  = wdt_ovf;
      pre_clr = wdt_clr;
    end else begin
      pre_in  = src_tick;
      pre_clr = tmr_wr;
    end
  end

  shpre_divider #(.W(PRE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .owner   (owner),
    .tick_in (pre_in),
    .clear   (pre_clr),
    .tap_sel (ratio),
    .div_tick(pre_out),
    .cnt     (pre_cnt)
  );

  assign tmr_inc = (owner == OWNER_WDT) ? src_tick : pre_out;

  shpre_timer_reg #(.W(TMR_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (tmr_wr),
    .wdata(tmr_wdata),
    .inc  (tmr_inc),
    .value(tmr_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= wdt_en & ((owner == OWNER_WDT) ? pre_out : wdt_ovf);
    end
  end

  assign wdt_timeout = timeout_q;
endmodule

// File: rtl/shpre_chk.sv
module shpre_chk #(
  parameter int PRE_W = 8,
  parameter int TMR_W = 8,
  parameter int WDT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic [TMR_W-1:0] tmr_value,
  input logic             wdt_en,
  input logic             wdt_clr,
  input logic             wdt_timeout,
  input logic             pre_clr,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [WDT_W-1:0] wdt_cnt
);
  // R6
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> (tmr_value == $past(tmr_wdata)));

  // R11
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && !cyc_en) |=> $stable(tmr_value));

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> ((tmr_value == $past(tmr_value)) ||
                 (tmr_value == $past(tmr_value) + TMR_W'(1))));

  // R7
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  // R10
  timeout_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> $past(wdt_en));

  // R9
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (wdt_cnt == '0));

  // R6
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> (pre_cnt == '0));
endmodule

bind shpre_top shpre_chk #(.PRE_W(PRE_W), .TMR_W(TMR_W), .WDT_W(WDT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_en     (cyc_en),
  .tmr_wr     (tmr_wr),
  .tmr_wdata  (tmr_wdata),
  .tmr_value  (tmr_value),
  .wdt_en     (wdt_en),
  .wdt_clr    (wdt_clr),
  .wdt_timeout(wdt_timeout),
  .pre_clr    (pre_clr),
  .pre_cnt    (pre_cnt),
  .wdt_cnt    (wdt_cnt)
);

// File: tb/shpre_top_tb.sv
module shpre_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       pin_fall = 1'b0;
  logic       src_pin = 1'b0;
  logic [2:0] ratio = 3'd0;
  logic       wdt_owns = 1'b0;
  logic       wdt_en = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = 8'h00;
  logic       wdt_clr = 1'b0;
  logic [7:0] tmr_value;
  logic       wdt_timeout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shpre_top #(.WDT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .pin_fall(pin_fall), .src_pin(src_pin), .ratio(ratio),
    .wdt_owns(wdt_owns), .wdt_en(wdt_en), .wdt_tick(wdt_tick),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_clr(wdt_clr),
    .tmr_value(tmr_value), .wdt_timeout(wdt_timeout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tmr_write(input logic [7:0] d);
    tmr_wr = 1'b1; tmr_wdata = d;
    step();
    tmr_wr = 1'b0;
  endtask

  task automatic cyc_run(input int n);
    cyc_en = 1'b1;
    repeat (n) step();
    cyc_en = 1'b0;
  endtask

  task automatic wdt_pulse(output logic got);
    wdt_tick = 1'b1;
    step();
    wdt_tick = 1'b0;
    got = wdt_timeout;
  endtask

  task automatic wdt_clear();
    wdt_clr = 1'b1;
    step();
    wdt_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 timer after reset", 32'(tmr_value), 32'h0);
    check("R1 timeout after reset", 32'(wdt_timeout), 32'h0);
  endtask

  task automatic t_no_prescale();
    wdt_owns = 1'b1; src_pin = 1'b0;
    tmr_write(8'hFE);
    check("R6 write loads", 32'(tmr_value), 32'hFE);
    cyc_run(3);
    check("R3 undivided count and wrap", 32'(tmr_value), 32'h01);
  endtask

  task automatic t_ratios();
    wdt_owns = 1'b0;
    ratio = 3'd0; tmr_write(8'h00); cyc_run(10);
    check("R2 ratio 1:2", 32'(tmr_value), 32'h05);
    ratio = 3'd2; tmr_write(8'h10); cyc_run(20);
    check("R2 ratio 1:8", 32'(tmr_value), 32'h12);
    ratio = 3'd7; tmr_write(8'h00); cyc_run(255);
    check("R2 ratio 1:256 before boundary", 32'(tmr_value), 32'h00);
    cyc_run(1);
    check("R2 ratio 1:256 at boundary", 32'(tmr_value), 32'h01);
  endtask

  task automatic t_write_clear();
    wdt_owns = 1'b0; ratio = 3'd1;
    tmr_write(8'h00); cyc_run(3); tmr_write(8'h00); cyc_run(3);
    check("R6 write clears divider", 32'(tmr_value), 32'h00);
    cyc_run(1);
    check("R6 count after clear", 32'(tmr_value), 32'h01);
    repeat (5) step();
    check("R11 hold without cycle enable", 32'(tmr_value), 32'h01);
    // R9: watchdog clear leaves the timer-owned divider alone
    tmr_write(8'h00); cyc_run(3); wdt_clear(); cyc_run(1);
    check("R9 wdt clear keeps timer divider", 32'(tmr_value), 32'h01);
  endtask

  task automatic t_pin();
    wdt_owns = 1'b1; src_pin = 1'b1; pin_fall = 1'b0; ext_pin = 1'b0;
    cyc_en = 1'b1;
    repeat (5) step();
    tmr_write(8'h20);
    ext_pin = 1'b1;
    step(); step();
    check("R4 no count before sync latency", 32'(tmr_value), 32'h20);
    step();
    check("R4 rising pin counted after sync", 32'(tmr_value), 32'h21);
    repeat (4) step();
    check("R4 cycle enable alone not counted", 32'(tmr_value), 32'h21);
    ext_pin = 1'b0;
    repeat (5) step();
    check("R5 falling ignored in rising mode", 32'(tmr_value), 32'h21);
    pin_fall = 1'b1;
    repeat (5) step();
    tmr_write(8'h40);
    ext_pin = 1'b1;
    repeat (5) step();
    check("R5 rising ignored in falling mode", 32'(tmr_value), 32'h40);
    ext_pin = 1'b0;
    repeat (5) step();
    check("R5 falling counted in falling mode", 32'(tmr_value), 32'h41);
    cyc_en = 1'b0; src_pin = 1'b0; pin_fall = 1'b0;
  endtask

  task automatic t_wdt_plain();
    logic got;
    wdt_owns = 1'b0; wdt_en = 1'b1;
    wdt_clear();
    for (int i = 1; i <= 8; i++) begin
      wdt_pulse(got);
      check("R7 timeout every fourth tick", 32'(got), (i % 4 == 0) ? 32'h1 : 32'h0);
      if (i == 4) begin
        step();
        check("R7 timeout lasts one cycle", 32'(wdt_timeout), 32'h0);
      end
    end
    wdt_clear();
    repeat (3) wdt_pulse(got);
    wdt_clear();
    repeat (3) begin
      wdt_pulse(got);
      check("R9 clear restarts counter", 32'(got), 32'h0);
    end
    wdt_pulse(got);
    check("R9 timeout after full count", 32'(got), 32'h1);
  endtask

  task automatic t_wdt_div();
    logic got;
    int   hits;
    wdt_owns = 1'b1; wdt_en = 1'b1;
    ratio = 3'd2; wdt_clear(); hits = 0;
    for (int i = 1; i <= 16; i++) begin
      wdt_pulse(got);
      if (got) hits++;
      if (i == 16) check("R8 ratio 1:4 timeout at 16th tick", 32'(got), 32'h1);
    end
    check("R8 ratio 1:4 single timeout", 32'(hits), 32'h1);
    ratio = 3'd0; wdt_clear();
    for (int i = 1; i <= 4; i++) begin
      wdt_pulse(got);
      check("R8 ratio 1:1", 32'(got), (i == 4) ? 32'h1 : 32'h0);
    end
    ratio = 3'd1; wdt_clear();
    repeat (4) wdt_pulse(got);
    check("R8 ratio 1:2 first overflow", 32'(got), 32'h0);
    tmr_write(8'h00);
    repeat (4) wdt_pulse(got);
    check("R9 timer write keeps wdt divider", 32'(got), 32'h1);
    repeat (4) wdt_pulse(got);
    wdt_clear();
    repeat (4) wdt_pulse(got);
    check("R9 wdt clear clears divider", 32'(got), 32'h0);
    repeat (4) wdt_pulse(got);
    check("R9 timeout after clear", 32'(got), 32'h1);
  endtask

  task automatic t_wdt_off();
    logic got;
    int   hits;
    wdt_owns = 1'b0; wdt_clear(); wdt_en = 1'b0; hits = 0;
    repeat (8) begin
      wdt_pulse(got);
      if (got) hits++;
    end
    check("R10 no timeout while disabled", 32'(hits), 32'h0);
    wdt_en = 1'b1;
    repeat (3) wdt_pulse(got);
    check("R10 counter frozen while disabled", 32'(got), 32'h0);
    wdt_pulse(got);
    check("R10 count resumes when enabled", 32'(got), 32'h1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_prescale();
    t_ratios();
    t_write_clear();
    t_pin();
    t_wdt_plain();
    t_wdt_div();
    t_wdt_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule